// File: doc/BRIEF.md
# Receive Byte Queue with Overrun Latch

This block sits on the receive side of a serial port, between the bit-level deserializer and the processor. Each completed byte comes in on a one-cycle valid strobe and is stored in a 16-entry first-in first-out queue. The processor drains the queue with a read strobe. The popped byte appears on the read-data port in the following cycle. Occupancy is reported as a count and as full and empty flags.

A 16-bit line status word carries a single live bit, the overrun latch. The latch is set when a byte completes while the queue already holds 16 bytes. That byte is dropped and the stored bytes stay as they were. While the latch is set, a halt output tells the deserializer to stop, and the block takes no further bytes. Software cannot set the latch. To clear it, software must first read the status word while the latch shows 1, and then write a 0 to bit 0.

Top module: `rx_fifo_ovr`

## Requirements
- R1: After the asynchronous active-low reset, the queue is empty (count 0, empty 1, full 0), the overrun latch and the halt output are 0, and the read-data port is 0.
- R2: A byte is taken when rx_valid and rx_en are both 1 and the latch is 0. Taken bytes are popped in arrival order. The byte removed by a read strobe is on rd_data one cycle after the strobe, and rd_data keeps that value until the next strobe. A push and a pop in the same cycle are both carried out.
- R3: A read strobe while the queue is empty sets rd_data to 0 and leaves the count unchanged.
- R4: count equals the number of stored bytes, from 0 to 16. full is 1 exactly when count is 16, and empty is 1 exactly when count is 0.
- R5: Bits 15 to 1 of the status word always read 0, and writing them has no effect. Bit 0 is the overrun latch.
- R6: The latch becomes 1 in the cycle after a byte that would otherwise be taken (R2) arrives while full is 1. That byte is discarded and the 16 stored bytes are kept unchanged. A pop in that same cycle is still carried out.
- R7: rx_halt equals the latch. While rx_halt is 1, bytes on rx_valid are ignored and the count changes only through pops.
- R8: Writing 1 to bit 0 never sets the latch. Writing 0 leaves the latch set unless a status read returned the latch as 1 after it was last set.
- R9: A status read that returns 1, followed later by a write of 0 to bit 0, clears the latch and drops rx_halt in the cycle after the write. Once the latch is cleared, another write of 0 needs a fresh qualifying read.
- R10: While rx_en is 0, arriving bytes are not stored, and the overrun latch keeps its value.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| rx_valid | input | 1 | One-cycle strobe marking a completed byte |
| rx_data | input | 8 | Completed byte |
| rd_fifo | input | 1 | Pop strobe from the processor |
| rd_data | output | 8 | Last popped byte, or 0 after a pop while empty |
| sts_rd | input | 1 | Status word read strobe |
| sts_wr | input | 1 | Status word write strobe |
| sts_wdata | input | 16 | Status word write data |
| sts_rdata | output | 16 | Status word, with the overrun latch in bit 0 |
| rx_halt | output | 1 | Stop request to the deserializer |
| count | output | 5 | Number of stored bytes |
| full | output | 1 | Queue holds 16 bytes |
| empty | output | 1 | Queue holds no bytes |

## Verification
Simple push-then-pop bursts and mixed push-and-pop cycles test ordering and pointer wrap. Pops while empty and pushes with rx_en low confirm that these cases change nothing. Filling the queue and then sending one more byte tests the overrun point. Sending more bytes while halted shows whether they are really dropped, and draining afterwards shows that the original 16 bytes survived. The clearing handshake is tried in four ways: writing 1, writing 0 without a read, writing 0 after a read that returned 0 before the overrun, and the proper read-1-then-write-0 sequence. This separates a correct arm bit from one that is missing or too permissive.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_DEPTH = 16;
  localparam int unsigned RXF_DW    = 8;
  localparam int unsigned RXF_SR_W  = 16;

  typedef struct packed {
    logic flag;   // overrun latch
    logic armed;  // latch was read as 1 since it was last set
  } ovr_state_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic slot_en;
      assign slot_en = push_ok && (wptr_q == AW'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem[gi] <= '0;
        else if (slot_en) mem[gi] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    if (push_ok)
      wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (pop_ok) begin
      rptr_d  = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
      rdata_d = mem[rptr_q];
    end else if (pop) begin
      rdata_d = '0;
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign count = cnt_q;
endmodule

// File: rtl/rxf_ovr_ctl.sv
module rxf_ovr_ctl
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic sts_rd,
  input  logic sts_wr,
  input  logic wr_bit0,
  output logic flag
);
  ovr_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (sts_rd && st_q.flag)
      st_d.armed = 1'b1;
    if (sts_wr && !wr_bit0 && st_q.flag && st_q.armed) begin
      st_d.flag  = 1'b0;
      st_d.armed = 1'b0;
    end
    if (ovr_evt) begin
      st_d.flag  = 1'b1;
      st_d.armed = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign flag = st_q.flag;
endmodule

// File: rtl/rx_fifo_ovr.sv
module rx_fifo_ovr
  import rxf_pkg::*;
#(
  parameter int unsigned DW    = RXF_DW,
  parameter int unsigned DEPTH = RXF_DEPTH,
  parameter int unsigned SR_W  = RXF_SR_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_data,
  input  logic            rd_fifo,
  output logic [DW-1:0]   rd_data,
  input  logic            sts_rd,
  input  logic            sts_wr,
  input  logic [SR_W-1:0] sts_wdata,
  output logic [SR_W-1:0] sts_rdata,
  output logic            rx_halt,
  output logic [CW-1:0]   count,
  output logic            full,
  output logic            empty
);
  logic flag;
  logic take, push, ovr_evt;

  assign take    = rx_valid && rx_en && !flag;
  assign push    = take && !full;
  assign ovr_evt = take && full;

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (rx_data),
    .pop   (rd_fifo),
    .rdata (rd_data),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  rxf_ovr_ctl u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovr_evt (ovr_evt),
    .sts_rd  (sts_rd),
    .sts_wr  (sts_wr),
    .wr_bit0 (sts_wdata[0]),
    .flag    (flag)
  );

  assign sts_rdata = {{(SR_W-1){1'b0}}, flag};
  assign rx_halt   = flag;
endmodule

// File: rtl/rx_fifo_ovr_chk.sv
module rx_fifo_ovr_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SR_W  = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_en,
  input logic            rx_valid,
  input logic            rd_fifo,
  input logic            sts_wr,
  input logic [SR_W-1:0] sts_wdata,
  input logic [SR_W-1:0] sts_rdata,
  input logic            rx_halt,
  input logic [CW-1:0]   count,
  input logic            full,
  input logic            empty
);
  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rdata[SR_W-1:1] == '0);

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CW'(DEPTH)) && (full == (count == CW'(DEPTH))) && (empty == (count == '0)));

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en && full && !rx_halt) |=> sts_rdata[0]);

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt && !rd_fifo) |=> (count == $past(count)));

  // R8
  no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_rdata[0] && !(rx_valid && rx_en && full)) |=> !sts_rdata[0]);

  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rdata[0] && !(sts_wr && !sts_wdata[0])) |=> sts_rdata[0]);
endmodule

bind rx_fifo_ovr rx_fifo_ovr_chk #(.DW(DW), .DEPTH(DEPTH), .SR_W(SR_W)) u_chk (.*);

// File: tb/tb_rx_fifo_ovr.sv
module tb_rx_fifo_ovr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_en, rx_valid, rd_fifo, sts_rd, sts_wr;
  logic [7:0]  rx_data, rd_data;
  logic [15:0] sts_wdata, sts_rdata;
  logic        rx_halt, full, empty;
  logic [4:0]  count;

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  byte unsigned q[$];
  bit           m_flag, m_armed;
  byte unsigned m_rdata;

  always #5 clk = ~clk;

  rx_fifo_ovr dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 rd_data", rd_data, m_rdata);
    check("R4 count", count, q.size());
    check("R4 full", full, q.size() == 16);
    check("R4 empty", empty, q.size() == 0);
    check("R5 reserved", sts_rdata[15:1], 0);
    check("R6 flag", sts_rdata[0], m_flag);
    check("R7 halt", rx_halt, m_flag);
  endtask

  task automatic step(input bit v, input byte unsigned d, input bit en,
                      input bit pop, input bit rd, input bit wr, input logic [15:0] wd);
    bit take, was_full, clr;
    rx_valid = v; rx_data = d; rx_en = en; rd_fifo = pop;
    sts_rd = rd; sts_wr = wr; sts_wdata = wd;
    @(posedge clk);
    take     = v && en && !m_flag;
    was_full = (q.size() == 16);
    if (pop) m_rdata = (q.size() > 0) ? q.pop_front() : 8'h00;
    if (take && !was_full) q.push_back(d);
    clr = wr && !wd[0] && m_flag && m_armed;
    if (rd && m_flag) m_armed = 1;
    if (clr) begin m_flag = 0; m_armed = 0; end
    if (take && was_full) begin m_flag = 1; m_armed = 0; end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); step(0, 0, 1, 0, 0, 0, 16'h0); endtask
  task automatic push(input byte unsigned d); step(1, d, 1, 0, 0, 0, 16'h0); endtask
  task automatic pop1(); step(0, 0, 1, 1, 0, 0, 16'h0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_en = 0; rx_valid = 0; rx_data = 0; rd_fifo = 0;
    sts_rd = 0; sts_wr = 0; sts_wdata = 0;
    m_flag = 0; m_armed = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 flag", sts_rdata, 0);
    check("R1 halt", rx_halt, 0);
    check("R1 rd_data", rd_data, 0);
    rst_n = 1;
    idle();

    // R2 ordered burst
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) begin
      pop1();
      check("R2 order", rd_data, 8'hA0 + i);
    end
    // R3 pop while empty
    pop1();
    check("R3 empty pop data", rd_data, 0);
    check("R3 empty pop count", count, 0);
    // R3 push together with empty pop
    step(1, 8'h3C, 1, 1, 0, 0, 16'h0);
    check("R3 push during empty pop", count, 1);
    // R2 simultaneous push and pop, pointer wrap
    for (int i = 0; i < 20; i++) step(1, 8'(i + 8'h40), 1, 1, 0, 0, 16'h0);
    pop1();
    check("R2 last after mixed", rd_data, 8'h53);
    // R10 bytes ignored while disabled
    step(1, 8'h99, 0, 0, 0, 0, 16'h0);
    check("R10 disabled push", count, 0);

    // R4 fill to 16
    for (int i = 0; i < 16; i++) push(8'(i));
    check("R4 full at 16", full, 1);
    // status read with latch 0 must not arm (R8)
    step(0, 0, 1, 0, 1, 0, 16'h0);
    // R6 overrun
    push(8'hEE);
    check("R6 overrun set", sts_rdata[0], 1);
    check("R6 count kept", count, 16);
    // R8 write 0 after only a read-as-0
    step(0, 0, 1, 0, 0, 1, 16'h0000);
    check("R8 unarmed clear", sts_rdata[0], 1);
    // R8 write 1 / reserved bits
    step(0, 0, 1, 0, 0, 1, 16'hFFFF);
    check("R8 write one", sts_rdata[0], 1);
    check("R5 reserved after write", sts_rdata[15:1], 0);
    // R7 bytes ignored while halted, pop still works
    push(8'h55);
    check("R7 halted push", count, 16);
    step(1, 8'h56, 1, 1, 0, 0, 16'h0);
    check("R7 halted pop", count, 15);
    check("R6 head kept", rd_data, 0);
    // R10 disabling keeps latch
    step(0, 0, 0, 0, 0, 0, 16'h0);
    check("R10 latch kept", sts_rdata[0], 1);
    // R9 handshake
    step(0, 0, 1, 0, 1, 0, 16'h0);
    step(0, 0, 1, 0, 0, 1, 16'hFFFE);
    check("R9 cleared", sts_rdata[0], 0);
    check("R9 halt dropped", rx_halt, 0);
    push(8'h77);
    check("R9 reception resumes", count, 16);
    // R6 second overrun with pop in the same cycle; R9 arm consumed
    step(1, 8'h88, 1, 1, 0, 0, 16'h0);
    check("R6 overrun with pop", sts_rdata[0], 1);
    check("R6 pop done", rd_data, 1);
    step(0, 0, 1, 0, 0, 1, 16'h0);
    check("R9 stale arm", sts_rdata[0], 1);
    step(0, 0, 1, 0, 1, 1, 16'h0);
    check("R9 read same cycle not enough", sts_rdata[0], 1);
    step(0, 0, 1, 0, 0, 1, 16'h0);
    check("R9 second clear", sts_rdata[0], 0);
    // drain and verify kept data
    for (int i = 0; i < 15; i++) pop1();
    check("R6 last kept byte", rd_data, 8'h77);
    check("R4 drained", empty, 1);
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule